// File: doc/BRIEF.md
# Descriptor-Driven FIFO/Host-Memory DMA Engine

This block moves data between two application-side FIFOs and host memory through a 256-bit request stream toward a PCIe endpoint and a 256-bit completion stream back from it. A control block hands over one descriptor at a time. Each descriptor holds a 64-bit host byte address, a direction flag and a length counted in 32-bit words. The datapath is meant to run at 250 MHz, and each FIFO word is exactly one stream beat wide.

When the direction is toward the host, the engine drains the transmit FIFO and sends memory-write packets: a header beat followed by payload beats. When the direction is from the host, it sends header-only memory-read requests. It keeps one read outstanding at a time and streams the returned completion beats straight into the receive FIFO. The transfer is cut into requests bounded by a maximum payload size and by 4 KB address pages. The block reports the remaining word count while it works. At the end it raises a one-cycle done pulse together with the address that follows the last transferred byte.

Top module: `fifo_host_dma`

## Requirements
- R1: `desc_ready` is high only while the engine is idle. A descriptor is taken on a clock edge where `desc_valid` and `desc_ready` are both high. The low 5 address bits are ignored, so the transfer starts at the enclosing 32-byte boundary.
- R2: Each request covers `min(words remaining, MAX_PAYLOAD_BYTES/4, dwords left before the next 4 KB address boundary)` dwords. Requests follow one another with contiguous addresses until the descriptor length is used up.
- R3: A request starts with a header beat. The header holds the 64-bit address in data bits [63:0], the dword count in bits [74:64], the type in bits [76:75] (2'b01 memory write, 2'b10 memory read) and the tag in bits [84:77]. All other bits are zero. The header beat carries `rq_tkeep` 8'h0F, and `rq_tlast` is high on it exactly for a read.
- R4: A write header is followed by ceil(dwords/8) payload beats. These are consecutive transmit FIFO words, in FIFO order. Every payload beat has `rq_tkeep` 8'hFF except the last, which keeps only the low (dwords mod 8, or 8) dwords and carries `rq_tlast`.
- R5: A write header is presented only once `txf_count` covers every payload beat of that request. `txf_rd` is never high while `txf_count` is zero, and `rq_tvalid` never drops between a write header and its last beat.
- R6: Only one read request is outstanding at a time. Read tags count up from 0 after reset, one per read request, modulo 256.
- R7: `cc_tready` is high only while a read is waiting for its data and `rxf_full` is low. Each accepted completion beat appears on `rxf_wdata` with `rxf_wr` in the same cycle. A read is complete once the dwords flagged in `cc_tkeep` add up to its length.
- R8: While `rq_tvalid` is high and `rq_tready` is low, the request beat (`rq_tdata`, `rq_tkeep`, `rq_tlast`) stays unchanged on the next cycle.
- R9: When the remaining count reaches zero and the last request beat has left, `done` is high for exactly one cycle. At that point `done_addr` equals the aligned start address plus 4 × length. A zero-length descriptor produces this pulse with the aligned start address and issues no request.
- R10: After reset, `desc_ready` is high and `done`, `rq_tvalid`, `txf_rd`, `rxf_wr` and `cc_tready` are low.
- R11: `words_left` equals the descriptor length on the cycle after acceptance, drops by each request's length as that request finishes, and is zero at `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Engine idle, descriptor can be taken |
| desc_addr | input | ADDR_W | Host byte address of the transfer |
| desc_to_host | input | 1 | 1: FIFO to host memory, 0: host memory to FIFO |
| desc_words | input | LEN_W | Transfer length in 32-bit words |
| txf_rdata | input | DATA_W | Head word of the transmit FIFO (show-ahead) |
| txf_count | input | TXCNT_W | Words held in the transmit FIFO |
| txf_rd | output | 1 | Pop the transmit FIFO head |
| rxf_wdata | output | DATA_W | Word written to the receive FIFO |
| rxf_wr | output | 1 | Receive FIFO write strobe |
| rxf_full | input | 1 | Receive FIFO cannot take a word |
| rq_tdata | output | DATA_W | Request stream data |
| rq_tkeep | output | DATA_W/32 | Request stream dword enables |
| rq_tlast | output | 1 | Last beat of a request |
| rq_tvalid | output | 1 | Request beat valid |
| rq_tready | input | 1 | Endpoint accepts request beat |
| cc_tdata | input | DATA_W | Completion payload beat |
| cc_tkeep | input | DATA_W/32 | Completion dword enables |
| cc_tvalid | input | 1 | Completion beat valid |
| cc_tready | output | 1 | Engine accepts completion beat |
| words_left | output | LEN_W | Dwords still to transfer |
| done | output | 1 | One-cycle end-of-descriptor pulse |
| done_addr | output | ADDR_W | Address following the last transferred byte |

## Verification
The bench targets transfers whose length crosses a 4 KB page partway through a payload-sized piece. A wrong split would show up as a header whose length runs past the page or as a gap in the address sequence. It feeds the transmit FIFO slowly, so a design that started a write before the whole payload was present would pop an empty FIFO or leave a hole inside a packet. Random back-pressure on both streams, together with a receive FIFO that reports full at random, catches beats that change while stalled and writes made into a full FIFO. Zero-length, unaligned-address and one-dword descriptors check the end pulse, the reported final address, and the partial keep on a last beat.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLAN,
    ST_HDR,
    ST_DATA,
    ST_WAIT,
    ST_ADV,
    ST_FIN
  } dma_state_e;

  localparam int HDR_W        = 128;
  localparam int HDR_LEN_LSB  = 64;
  localparam int HDR_LEN_W    = 11;
  localparam int HDR_TYPE_LSB = 75;
  localparam int HDR_TAG_LSB  = 77;
  localparam int HDR_TAG_W    = 8;

  localparam logic [1:0] REQ_MWR = 2'b01;
  localparam logic [1:0] REQ_MRD = 2'b10;

  function automatic logic [HDR_W-1:0] pack_hdr(
    input logic [63:0]          addr,
    input logic [HDR_LEN_W-1:0] dwords,
    input logic [1:0]           kind,
    input logic [HDR_TAG_W-1:0] tag
  );
    logic [HDR_W-1:0] h;
    h = '0;
    h[63:0] = addr;
    h[HDR_LEN_LSB +: HDR_LEN_W] = dwords;
    h[HDR_TYPE_LSB +: 2] = kind;
    h[HDR_TAG_LSB +: HDR_TAG_W] = tag;
    return h;
  endfunction

endpackage

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
  parameter int LEN_W             = 20,
  parameter int MAX_PAYLOAD_BYTES = 256,
  parameter int CHUNK_W           = 11
) (
  input  logic [11:0]        addr_lo,
  input  logic [LEN_W-1:0]   remaining,
  output logic [CHUNK_W-1:0] chunk
);
  localparam int MPS_DW = MAX_PAYLOAD_BYTES / 4;

  logic [12:0] page_bytes;
  logic [10:0] page_dw;
  logic [10:0] cap_dw;

  always_comb begin
    page_bytes = 13'h1000 - {1'b0, addr_lo};
    page_dw    = page_bytes[12:2];
    cap_dw     = (32'(page_dw) < MPS_DW) ? page_dw : 11'(MPS_DW);
    if (32'(remaining) < 32'(cap_dw)) chunk = CHUNK_W'(remaining);
    else                              chunk = CHUNK_W'(cap_dw);
  end
endmodule

// File: rtl/dma_rq_slice.sv
module dma_rq_slice #(
  parameter int DATA_W = 256,
  parameter int KEEP_W = DATA_W / 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [KEEP_W-1:0] ld_keep,
  input  logic              ld_last,
  output logic              slot_free,
  output logic [DATA_W-1:0] rq_tdata,
  output logic [KEEP_W-1:0] rq_tkeep,
  output logic              rq_tlast,
  output logic              rq_tvalid,
  input  logic              rq_tready
);
  assign slot_free = !rq_tvalid || rq_tready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_tvalid <= 1'b0;
    end else if (load) begin
      rq_tvalid <= 1'b1;
    end else if (rq_tready) begin
      rq_tvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_tdata <= '0;
      rq_tkeep <= '0;
      rq_tlast <= 1'b0;
    end else if (load) begin
      rq_tdata <= ld_data;
      rq_tkeep <= ld_keep;
      rq_tlast <= ld_last;
    end
  end
endmodule

// File: rtl/dma_cpl_sink.sv
module dma_cpl_sink #(
  parameter int DATA_W  = 256,
  parameter int KEEP_W  = DATA_W / 32,
  parameter int CHUNK_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm,
  input  logic [CHUNK_W-1:0] target,
  input  logic [DATA_W-1:0]  cc_tdata,
  input  logic [KEEP_W-1:0]  cc_tkeep,
  input  logic               cc_tvalid,
  output logic               cc_tready,
  input  logic               rxf_full,
  output logic               rxf_wr,
  output logic [DATA_W-1:0]  rxf_wdata,
  output logic               finished
);
  logic [CHUNK_W-1:0] got;
  logic               reached;

  assign reached   = (got >= target);
  assign finished  = arm && reached;
  assign cc_tready = arm && !reached && !rxf_full;
  assign rxf_wr    = cc_tvalid && cc_tready;
  assign rxf_wdata = cc_tdata;

  always_ff @(posedge clk) begin
    if (rst || !arm) got <= '0;
    else if (rxf_wr) got <= got + CHUNK_W'($countones(cc_tkeep));
  end
endmodule

// File: rtl/fifo_host_dma.sv
module fifo_host_dma
  import dma_pkg::*;
#(
  parameter int DATA_W            = 256,
  parameter int ADDR_W            = 64,
  parameter int LEN_W             = 20,
  parameter int MAX_PAYLOAD_BYTES = 256,
  parameter int TAG_W             = 8,
  parameter int TXCNT_W           = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 desc_valid,
  output logic                 desc_ready,
  input  logic [ADDR_W-1:0]    desc_addr,
  input  logic                 desc_to_host,
  input  logic [LEN_W-1:0]     desc_words,
  input  logic [DATA_W-1:0]    txf_rdata,
  input  logic [TXCNT_W-1:0]   txf_count,
  output logic                 txf_rd,
  output logic [DATA_W-1:0]    rxf_wdata,
  output logic                 rxf_wr,
  input  logic                 rxf_full,
  output logic [DATA_W-1:0]    rq_tdata,
  output logic [DATA_W/32-1:0] rq_tkeep,
  output logic                 rq_tlast,
  output logic                 rq_tvalid,
  input  logic                 rq_tready,
  input  logic [DATA_W-1:0]    cc_tdata,
  input  logic [DATA_W/32-1:0] cc_tkeep,
  input  logic                 cc_tvalid,
  output logic                 cc_tready,
  output logic [LEN_W-1:0]     words_left,
  output logic                 done,
  output logic [ADDR_W-1:0]    done_addr
);
  localparam int KEEP_W   = DATA_W / 32;
  localparam int BEAT_SH  = $clog2(KEEP_W);
  localparam int ALIGN_SH = $clog2(DATA_W / 8);
  localparam int CHUNK_W  = HDR_LEN_W;
  localparam int BEAT_W   = CHUNK_W - BEAT_SH + 1;

  dma_state_e         state;
  logic [ADDR_W-1:0]  cur_addr;
  logic [LEN_W-1:0]   left_q;
  logic               to_host_q;
  logic [CHUNK_W-1:0] chunk_q;
  logic [CHUNK_W-1:0] chunk_c;
  logic [BEAT_W-1:0]  beats_q;
  logic [BEAT_W-1:0]  beats_c;
  logic [BEAT_W-1:0]  beat_idx;
  logic [TAG_W-1:0]   tag_q;

  logic              ld;
  logic [DATA_W-1:0] ld_data;
  logic [KEEP_W-1:0] ld_keep;
  logic              ld_last;
  logic              slot_free;
  logic              cpl_finished;
  logic [KEEP_W-1:0] tail_keep;
  logic              last_beat;

  dma_chunk_calc #(
    .LEN_W(LEN_W), .MAX_PAYLOAD_BYTES(MAX_PAYLOAD_BYTES), .CHUNK_W(CHUNK_W)
  ) calc_i (
    .addr_lo(cur_addr[11:0]), .remaining(left_q), .chunk(chunk_c)
  );

  assign beats_c = BEAT_W'((32'(chunk_c) + KEEP_W - 1) >> BEAT_SH);

  dma_rq_slice #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) slice_i (
    .clk(clk), .rst(rst), .load(ld), .ld_data(ld_data), .ld_keep(ld_keep),
    .ld_last(ld_last), .slot_free(slot_free), .rq_tdata(rq_tdata),
    .rq_tkeep(rq_tkeep), .rq_tlast(rq_tlast), .rq_tvalid(rq_tvalid),
    .rq_tready(rq_tready)
  );

  dma_cpl_sink #(.DATA_W(DATA_W), .KEEP_W(KEEP_W), .CHUNK_W(CHUNK_W)) sink_i (
    .clk(clk), .rst(rst), .arm(state == ST_WAIT), .target(chunk_q),
    .cc_tdata(cc_tdata), .cc_tkeep(cc_tkeep), .cc_tvalid(cc_tvalid),
    .cc_tready(cc_tready), .rxf_full(rxf_full), .rxf_wr(rxf_wr),
    .rxf_wdata(rxf_wdata), .finished(cpl_finished)
  );

  // dword enables of the closing beat of a write payload
  always_comb begin
    int n;
    n = (chunk_q[BEAT_SH-1:0] == '0) ? KEEP_W : int'(chunk_q[BEAT_SH-1:0]);
    for (int i = 0; i < KEEP_W; i++) tail_keep[i] = (i < n);
  end

  assign last_beat  = (beat_idx == beats_q - BEAT_W'(1));
  assign desc_ready = (state == ST_IDLE);
  assign words_left = left_q;

  always_comb begin
    ld      = 1'b0;
    ld_data = '0;
    ld_keep = '0;
    ld_last = 1'b0;
    txf_rd  = 1'b0;
    case (state)
      ST_HDR: if (slot_free) begin
        ld      = 1'b1;
        ld_data = DATA_W'(pack_hdr(64'(cur_addr), chunk_q,
                                   to_host_q ? REQ_MWR : REQ_MRD,
                                   HDR_TAG_W'(tag_q)));
        ld_keep = KEEP_W'(4'hF);
        ld_last = !to_host_q;
      end
      ST_DATA: if (slot_free) begin
        ld      = 1'b1;
        txf_rd  = 1'b1;
        ld_data = txf_rdata;
        ld_keep = last_beat ? tail_keep : '1;
        ld_last = last_beat;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      left_q    <= '0;
      to_host_q <= 1'b0;
      chunk_q   <= '0;
      beats_q   <= '0;
      beat_idx  <= '0;
      tag_q     <= '0;
      done      <= 1'b0;
      done_addr <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (desc_valid) begin
          cur_addr  <= {desc_addr[ADDR_W-1:ALIGN_SH], {ALIGN_SH{1'b0}}};
          left_q    <= desc_words;
          to_host_q <= desc_to_host;
          state     <= (desc_words == '0) ? ST_FIN : ST_PLAN;
        end
        ST_PLAN: begin
          chunk_q <= chunk_c;
          beats_q <= beats_c;
          if (!to_host_q || 32'(txf_count) >= 32'(beats_c)) state <= ST_HDR;
        end
        ST_HDR: if (slot_free) begin
          beat_idx <= '0;
          state    <= to_host_q ? ST_DATA : ST_WAIT;
        end
        ST_DATA: if (slot_free) begin
          beat_idx <= beat_idx + BEAT_W'(1);
          if (last_beat) state <= ST_ADV;
        end
        ST_WAIT: if (cpl_finished) state <= ST_ADV;
        ST_ADV: begin
          cur_addr <= cur_addr + ADDR_W'({chunk_q, 2'b00});
          left_q   <= left_q - LEN_W'(chunk_q);
          if (!to_host_q) tag_q <= tag_q + TAG_W'(1);
          state    <= (left_q == LEN_W'(chunk_q)) ? ST_FIN : ST_PLAN;
        end
        ST_FIN: if (!rq_tvalid) begin
          done      <= 1'b1;
          done_addr <= cur_addr;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fifo_host_dma_chk.sv
module fifo_host_dma_chk #(
  parameter int DATA_W            = 256,
  parameter int MAX_PAYLOAD_BYTES = 256,
  parameter int TXCNT_W           = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DATA_W-1:0]    rq_tdata,
  input logic [DATA_W/32-1:0] rq_tkeep,
  input logic                 rq_tlast,
  input logic                 rq_tvalid,
  input logic                 rq_tready,
  input logic                 txf_rd,
  input logic [TXCNT_W-1:0]   txf_count,
  input logic                 rxf_wr,
  input logic                 rxf_full,
  input logic                 cc_tready,
  input logic                 done
);
  logic sop;
  logic in_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sop   <= 1'b1;
      in_wr <= 1'b0;
    end else if (rq_tvalid && rq_tready) begin
      sop   <= rq_tlast;
      in_wr <= !rq_tlast;
    end
  end

  AST_RQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rq_tvalid && !rq_tready) |=> (rq_tvalid && $stable(rq_tdata) && $stable(rq_tkeep) && $stable(rq_tlast))); // R8
  AST_NO_4K_CROSS: assert property (@(posedge clk) disable iff (rst)
    (sop && rq_tvalid) |-> (({1'b0, rq_tdata[11:0]} + {rq_tdata[74:64], 2'b00}) <= 13'h1000)); // R2
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    (sop && rq_tvalid) |-> (rq_tdata[74:64] != 11'd0 && 32'(rq_tdata[74:64]) <= MAX_PAYLOAD_BYTES / 4)); // R2
  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    in_wr |-> rq_tvalid); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    txf_rd |-> (txf_count != '0)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    rxf_full |-> (!rxf_wr && !cc_tready)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
endmodule

bind fifo_host_dma fifo_host_dma_chk #(
  .DATA_W(DATA_W), .MAX_PAYLOAD_BYTES(MAX_PAYLOAD_BYTES), .TXCNT_W(TXCNT_W)
) chk_i (
  .clk(clk), .rst(rst), .rq_tdata(rq_tdata), .rq_tkeep(rq_tkeep),
  .rq_tlast(rq_tlast), .rq_tvalid(rq_tvalid), .rq_tready(rq_tready),
  .txf_rd(txf_rd), .txf_count(txf_count), .rxf_wr(rxf_wr),
  .rxf_full(rxf_full), .cc_tready(cc_tready), .done(done)
);

// File: tb/fifo_host_dma_tb_top.sv
module fifo_host_dma_tb_top;
  localparam int CLK_PERIOD = 4;
  localparam int DW   = 256;
  localparam int KW   = DW / 32;
  localparam int MPS  = 256;
  localparam int LENW = 20;
  localparam int TXW  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic            desc_valid, desc_ready, desc_to_host;
  logic [63:0]     desc_addr;
  logic [LENW-1:0] desc_words;
  logic [DW-1:0]   txf_rdata, rxf_wdata, rq_tdata, cc_tdata;
  logic [TXW-1:0]  txf_count;
  logic            txf_rd, rxf_wr, rxf_full, rq_tlast, rq_tvalid, rq_tready;
  logic [KW-1:0]   rq_tkeep, cc_tkeep;
  logic            cc_tvalid, cc_tready, done;
  logic [LENW-1:0] words_left;
  logic [63:0]     done_addr;

  fifo_host_dma #(.DATA_W(DW), .ADDR_W(64), .LEN_W(LENW), .MAX_PAYLOAD_BYTES(MPS),
                  .TAG_W(8), .TXCNT_W(TXW)) dut_i (
    .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_addr(desc_addr), .desc_to_host(desc_to_host), .desc_words(desc_words),
    .txf_rdata(txf_rdata), .txf_count(txf_count), .txf_rd(txf_rd),
    .rxf_wdata(rxf_wdata), .rxf_wr(rxf_wr), .rxf_full(rxf_full),
    .rq_tdata(rq_tdata), .rq_tkeep(rq_tkeep), .rq_tlast(rq_tlast),
    .rq_tvalid(rq_tvalid), .rq_tready(rq_tready), .cc_tdata(cc_tdata),
    .cc_tkeep(cc_tkeep), .cc_tvalid(cc_tvalid), .cc_tready(cc_tready),
    .words_left(words_left), .done(done), .done_addr(done_addr)
  );

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  function automatic logic [DW-1:0] txw(input int i);
    logic [DW-1:0] w;
    for (int j = 0; j < KW; j++) w[32*j +: 32] = 32'hA500_0000 | (32'(i) << 4) | 32'(j);
    return w;
  endfunction

  function automatic logic [31:0] hm(input logic [63:0] a);
    return a[33:2] ^ a[63:32] ^ 32'h3C00_0000;
  endfunction

  function automatic int exp_chunk(input logic [63:0] a, input int left);
    int lim, to4k;
    lim  = MPS / 4;
    to4k = (4096 - int'(a[11:0])) / 4;
    if (to4k < lim) lim = to4k;
    return (left < lim) ? left : lim;
  endfunction

  function automatic logic [KW-1:0] keep_of(input int n);
    logic [KW-1:0] k;
    for (int j = 0; j < KW; j++) k[j] = (j < n);
    return k;
  endfunction

  // expectation state shared by monitor and stimulus
  logic [63:0] e_addr, e_fin, rx_base, pend_addr;
  int e_left = 0, e_tag = 0, tx_idx = 0, rx_k = 0, rx_total = 0;
  bit e_wr = 0;
  int pend = 0, pend_dw = 0;
  int m_chunk = 0, m_beat = 0;
  bit m_sop = 1;
  bit hold_v = 0;
  logic [DW-1:0] hold_d;
  int tx_head = 0, tx_tail = 0, tx_target = 0;
  bit stress = 0;

  assign txf_rdata = txw(tx_head);
  assign txf_count = TXW'(tx_tail - tx_head);

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_v) chk(rq_tvalid && rq_tdata == hold_d, "R8", "stalled beat changed", rq_tdata, hold_d);
      hold_v = rq_tvalid && !rq_tready;
      hold_d = rq_tdata;
      if (txf_rd) chk(txf_count != 0, "R5", "pop of empty tx fifo", DW'(txf_count), 1);
      if (rxf_wr) begin
        logic [DW-1:0] ew;
        for (int j = 0; j < KW; j++)
          ew[32*j +: 32] = (rx_k * KW + j < rx_total) ? hm(rx_base + 64'(32 * rx_k + 4 * j)) : 32'h0;
        chk(!rxf_full, "R7", "write while rx full", 1, 0);
        chk(rxf_wdata == ew, "R7", "rx fifo data", rxf_wdata, ew);
        rx_k++;
      end
      if (rq_tvalid && rq_tready) begin
        if (m_sop) begin
          int c;
          c = exp_chunk(e_addr, e_left);
          chk(rq_tdata[63:0] == e_addr, "R2", "request address", DW'(rq_tdata[63:0]), DW'(e_addr));
          chk(int'(rq_tdata[74:64]) == c, "R2", "request dwords", DW'(rq_tdata[74:64]), DW'(c));
          chk(rq_tdata[76:75] == (e_wr ? 2'b01 : 2'b10), "R3", "request type", DW'(rq_tdata[76:75]), DW'(e_wr ? 1 : 2));
          chk(rq_tdata[DW-1:85] == '0 && rq_tkeep == 8'h0F && rq_tlast == !e_wr, "R3", "header shape",
              DW'({rq_tkeep, rq_tlast}), DW'({8'h0F, !e_wr}));
          if (e_wr) begin
            chk(int'(txf_count) >= (c + KW - 1) / KW, "R5", "write started before data", DW'(txf_count), DW'((c + KW - 1) / KW));
          end else begin
            chk(rq_tdata[84:77] == 8'(e_tag), "R6", "read tag", DW'(rq_tdata[84:77]), DW'(8'(e_tag)));
            chk(pend == 0, "R6", "second read outstanding", DW'(pend), 0);
            e_tag++;
            pend_addr = e_addr;
            pend_dw   = c;
            pend++;
          end
          m_chunk = c;
          m_beat  = 0;
          e_addr  = e_addr + 64'(4 * c);
          e_left  = e_left - c;
        end else begin
          int nb, n;
          bit lb;
          nb = (m_chunk + KW - 1) / KW;
          lb = (m_beat == nb - 1);
          n  = lb ? m_chunk - KW * m_beat : KW;
          chk(rq_tdata == txw(tx_idx), "R4", "payload word", rq_tdata, txw(tx_idx));
          chk(rq_tlast == lb && rq_tkeep == keep_of(n), "R4", "payload keep/last",
              DW'({rq_tkeep, rq_tlast}), DW'({keep_of(n), lb}));
          tx_idx++;
          m_beat++;
        end
        m_sop = rq_tlast;
      end
      if (done) begin
        chk(done_addr == e_fin, "R9", "final address", DW'(done_addr), DW'(e_fin));
        chk(e_left == 0 && words_left == 0, "R11", "count at done", DW'(words_left), 0);
      end
    end
  end

  // transmit FIFO model: slow fill, pop on txf_rd
  initial begin
    bit rd;
    forever begin
      @(negedge clk);
      rd = txf_rd;
      @(posedge clk); #1;
      if (rd) tx_head++;
      if (tx_tail < tx_target && $urandom % 3 == 0) tx_tail++;
    end
  end

  // endpoint ready and receive FIFO full
  initial begin
    rq_tready = 1'b1;
    rxf_full  = 1'b0;
    forever begin
      @(posedge clk); #1;
      rq_tready = stress ? ($urandom % 4 != 0) : 1'b1;
      rxf_full  = stress ? ($urandom % 3 == 0) : 1'b0;
    end
  end

  // completer: answers one read at a time
  initial begin
    cc_tvalid = 1'b0;
    cc_tdata  = '0;
    cc_tkeep  = '0;
    forever begin
      @(posedge clk); #1;
      if (pend > 0) begin
        logic [63:0] a;
        int n;
        a = pend_addr;
        n = pend_dw;
        for (int b = 0; b < (n + KW - 1) / KW; b++) begin
          while (stress && $urandom % 4 == 0) begin @(posedge clk); #1; end
          for (int j = 0; j < KW; j++) begin
            cc_tkeep[j] = (b * KW + j < n);
            cc_tdata[32*j +: 32] = cc_tkeep[j] ? hm(a + 64'(4 * (b * KW + j))) : 32'h0;
          end
          cc_tvalid = 1'b1;
          do @(negedge clk); while (!cc_tready);
          @(posedge clk); #1;
          cc_tvalid = 1'b0;
          if (b == (n + KW - 1) / KW - 1) pend--;
        end
      end
    end
  end

  task automatic run(input logic [63:0] addr, input bit wr, input int words, input string req);
    logic [63:0] al, a;
    int left, c;
    al = {addr[63:5], 5'b0};
    e_addr = al; e_left = words; e_wr = wr;
    e_fin = al + 64'(4 * words);
    rx_base = al; rx_k = 0; rx_total = wr ? 0 : words;
    if (wr) begin
      a = al; left = words;
      while (left > 0) begin
        c = exp_chunk(a, left);
        tx_target += (c + KW - 1) / KW;
        a += 64'(4 * c);
        left -= c;
      end
    end
    @(posedge clk); #1;
    desc_valid = 1'b1; desc_addr = addr; desc_to_host = wr; desc_words = LENW'(words);
    do @(negedge clk); while (!desc_ready);
    @(posedge clk); #1;
    desc_valid = 1'b0;
    @(negedge clk);
    chk(!desc_ready, "R1", {req, " ready while busy"}, DW'(desc_ready), 0);
    chk(int'(words_left) == words, "R11", {req, " count after accept"}, DW'(words_left), DW'(words));
    do @(negedge clk); while (!done);
    chk(done_addr == e_fin, "R9", {req, " done address"}, DW'(done_addr), DW'(e_fin));
    @(negedge clk);
    chk(!done && desc_ready, "R9", {req, " pulse width"}, DW'(done), 0);
    if (!wr) chk(rx_k == (words + KW - 1) / KW, "R7", {req, " rx word count"}, DW'(rx_k), DW'((words + KW - 1) / KW));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    desc_valid = 1'b0; desc_addr = '0; desc_to_host = 1'b0; desc_words = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(desc_ready && !done && !rq_tvalid && !txf_rd && !rxf_wr && !cc_tready, "R10", "reset state",
        DW'({desc_ready, done, rq_tvalid, txf_rd, rxf_wr, cc_tready}), DW'(6'b100000));
    run(64'h0000_0000_0000_1000, 1, 64,  "R2 one full write");
    run(64'h0000_0000_0000_1FC0, 1, 203, "R4 write across 4K, partial tail");
    run(64'h0000_0000_0000_3F80, 0, 37,  "R7 read across 4K");
    run(64'h0000_0000_0000_5013, 0, 0,   "R9 zero length");
    run(64'h0000_00AB_CDEF_7FE7, 0, 1,   "R1 unaligned single dword");
    run(64'h0000_0000_0000_9000, 1, 1,   "R4 single dword write");
    stress = 1;
    for (int i = 0; i < 16; i++) begin
      logic [63:0] ra;
      ra = {$urandom, $urandom} & ~64'h1F;
      if (i % 4 == 0) ra[11:0] = 12'hFE0;
      run(ra, 1'($urandom % 2), int'($urandom % 300), "R6 random");
    end
    stress = 0;
    repeat (5) @(posedge clk);
    report();
    $finish;
  end
endmodule